// File: doc/BRIEF.md
# Bus Activity Monitor with Consecutive-Breach and Average Watermarks

This block watches bus traffic on several channels and raises an interrupt when a channel stays busier or quieter than programmed limits. Each channel adds a programmable weight to an accumulator for every activity event it sees. A shared timer divides an external tick into sampling periods. At the end of each period the channel does four things in the same cycle: it takes the accumulated count as the period sample, folds that sample into an exponentially smoothed average, compares the sample and the new average against their watermarks, and clears the accumulator.

A raw-count breach does not interrupt at once. The breach must persist for a programmable run of consecutive periods. Separate watermarks on the smoothed average catch slower drifts. Software programs all of this through a small register window: one global period register, one global status word with one bit per channel, and a register window for each channel. The default build has two channels, at 0x1C0 and 0x200. A frequency governor can read the average and status to choose a clock rate.

Top module: `am_monitor`

## Requirements
- R1: The global register at 0x004 holds P in bits 7:0. A sampling period ends on the tick pulse that completes P+1 ticks. Ticks only count while `tick_i` is high.
- R2: While channel control bits 31 (enable) and 18 (periodic) are both set, every cycle with the channel's event high adds the weight register (offset 0x18) to the accumulator. At a period end the average register (offset 0x20) becomes avg + ((sample − avg) >>> (K+1)), computed as a signed value. K is control bits 12:10. The accumulator then restarts from zero, and an event in that same cycle starts the new period.
- R3: A write to the seed register (offset 0x0C) loads the average directly.
- R4: If the sample is greater than the upper watermark (offset 0x04) for Nu+1 consecutive period ends, status bit 31 (offset 0x24) is set. Nu is control bits 28:26. A non-breaching period resets the run, and a completed run starts counting again from zero.
- R5: If the sample is less than the lower watermark (offset 0x08) for Nl+1 consecutive period ends, status bit 30 is set. Nl is control bits 25:23. Runs reset and restart as in R4.
- R6: At a period end, status bit 29 is set if the new average is greater than the average upper mark (offset 0x10). Status bit 28 is set if the new average is less than the average lower mark (offset 0x14).
- R7: Writing the status register clears every bit written as one. A bit set by a period end in the same cycle stays set.
- R8: `irq_o` is high when some enabled channel has a set status bit whose enable is set. Status bit 31 pairs with control bit 30, bit 30 with 29, bit 29 with 21, and bit 28 with 20.
- R9: The global status word at 0x000 shows channel i's interrupt condition in bit 26−i. No other bits are set.
- R10: While a channel is not both enabled and periodic, its accumulator and breach runs are held at zero. Its average and status do not change except through register writes.
- R11: After reset all registers read zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled time tick that advances the period timer |
| evt_i | input | NCH | One activity event per channel per cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Some properties are checked by assertions on every cycle. A period end never follows another one directly when P is nonzero. A disabled channel's average holds. An all-ones status write empties the status register. A breach run counter returns to zero after it fires. The interrupt output is never high while the global status word is zero. Other results can only be shown by the bench's scenarios: the exact arithmetic of the smoothed average, when runs of breaches complete under changing traffic density and period length, the interaction of clears with new events, and the values read back. These are compared every cycle against a bench model driven by dense, sparse and skewed random event patterns.

// File: rtl/am_pkg.sv
package am_pkg;
    localparam int DW       = 32;
    localparam int AW       = 12;
    localparam int KW       = 3;
    localparam int RUN_W    = 3;

    // control bit positions
    localparam int C_EN      = 31;
    localparam int C_RHI_EN  = 30;
    localparam int C_RLO_EN  = 29;
    localparam int C_NHI_LSB = 26;
    localparam int C_NLO_LSB = 23;
    localparam int C_AVHI_EN = 21;
    localparam int C_AVLO_EN = 20;
    localparam int C_PER     = 18;
    localparam int C_K_LSB   = 10;

    // status bit positions
    localparam int S_RHI  = 31;
    localparam int S_RLO  = 30;
    localparam int S_AVHI = 29;
    localparam int S_AVLO = 28;

    // channel-local offsets
    localparam logic [5:0] O_CTRL = 6'h00;
    localparam logic [5:0] O_HWM  = 6'h04;
    localparam logic [5:0] O_LWM  = 6'h08;
    localparam logic [5:0] O_SEED = 6'h0C;
    localparam logic [5:0] O_AHWM = 6'h10;
    localparam logic [5:0] O_ALWM = 6'h14;
    localparam logic [5:0] O_WGT  = 6'h18;
    localparam logic [5:0] O_AVG  = 6'h20;
    localparam logic [5:0] O_STAT = 6'h24;

    // global map
    localparam logic [AW-1:0] G_STAT    = 12'h000;
    localparam logic [AW-1:0] G_PER     = 12'h004;
    localparam logic [AW-1:0] CH_BASE0  = 12'h1C0;
    localparam logic [AW-1:0] CH_STRIDE = 12'h040;
    localparam int            GSTAT_TOP = 26;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] hwm;
        logic [DW-1:0] lwm;
        logic [DW-1:0] ahwm;
        logic [DW-1:0] alwm;
        logic [DW-1:0] wgt;
        logic [DW-1:0] acc;
        logic [DW-1:0] avg;
        logic [DW-1:0] stat;
    } chan_t;

    typedef struct packed {
        logic [7:0] per;
        logic [7:0] cnt;
    } tmr_t;
endpackage

// File: rtl/am_tick_timer.sv
module am_tick_timer #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [PW-1:0] wdata_i,
    input  logic          tick_i,
    output logic [PW-1:0] period_o,
    output logic          pend_o
);
    logic [PW-1:0] per_q, per_d;
    logic [PW-1:0] cnt_q, cnt_d;

    assign pend_o   = tick_i && (cnt_q == per_q);
    assign period_o = per_q;

    always_comb begin
        per_d = per_q;
        cnt_d = cnt_q;
        if (tick_i) cnt_d = pend_o ? '0 : cnt_q + 1'b1;
        if (wr_i)   per_d = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            cnt_q <= '0;
        end else begin
            per_q <= per_d;
            cnt_q <= cnt_d;
        end
    end

    // R1
    period_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && per_q != '0 && !wr_i) |=> !pend_o);
endmodule

// File: rtl/am_run.sv
module am_run #(
    parameter int NW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          samp_i,
    input  logic          breach_i,
    input  logic [NW-1:0] lim_i,
    output logic          hit_o
);
    logic [NW-1:0] cnt_q, cnt_d;

    assign hit_o = samp_i && breach_i && (cnt_q == lim_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (samp_i) cnt_d = (!breach_i || hit_o) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4, R5
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> cnt_q == '0);
endmodule

// File: rtl/am_chan.sv
module am_chan
    import am_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [5:0]    off_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          samp_i,
    input  logic          evt_i,
    output logic [DW-1:0] rdata_o,
    output logic          pend_o
);
    chan_t st_q, st_d;
    logic active, take;
    logic [1:0] breach, hit;
    logic [RUN_W-1:0] lim [2];
    logic signed [DW:0] diff, step;
    logic [3:0] shamt;
    logic [DW-1:0] avg_new;

    assign active    = st_q.ctrl[C_EN] && st_q.ctrl[C_PER];
    assign take      = active && samp_i;
    assign breach[0] = st_q.acc > st_q.hwm;
    assign breach[1] = st_q.acc < st_q.lwm;
    assign lim[0]    = st_q.ctrl[C_NHI_LSB +: RUN_W];
    assign lim[1]    = st_q.ctrl[C_NLO_LSB +: RUN_W];

    for (genvar g = 0; g < 2; g++) begin : g_run
        am_run #(.NW(RUN_W)) u_run (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (!active),
            .samp_i   (take),
            .breach_i (breach[g]),
            .lim_i    (lim[g]),
            .hit_o    (hit[g])
        );
    end

    assign shamt   = {1'b0, st_q.ctrl[C_K_LSB +: KW]} + 4'd1;
    assign diff    = $signed({1'b0, st_q.acc}) - $signed({1'b0, st_q.avg});
    assign step    = diff >>> shamt;
    assign avg_new = st_q.avg + step[DW-1:0];

    always_comb begin
        st_d = st_q;
        st_d.acc = active ? ((samp_i ? '0 : st_q.acc) + (evt_i ? st_q.wgt : '0)) : '0;
        st_d.stat = st_q.stat & ~((wr_i && off_i == O_STAT) ? wdata_i : '0);
        if (take) begin
            st_d.avg = avg_new;
            if (hit[0])               st_d.stat[S_RHI]  = 1'b1;
            if (hit[1])               st_d.stat[S_RLO]  = 1'b1;
            if (avg_new > st_q.ahwm)  st_d.stat[S_AVHI] = 1'b1;
            if (avg_new < st_q.alwm)  st_d.stat[S_AVLO] = 1'b1;
        end
        if (wr_i) begin
            case (off_i)
                O_CTRL: st_d.ctrl = wdata_i;
                O_HWM:  st_d.hwm  = wdata_i;
                O_LWM:  st_d.lwm  = wdata_i;
                O_SEED: st_d.avg  = wdata_i;
                O_AHWM: st_d.ahwm = wdata_i;
                O_ALWM: st_d.alwm = wdata_i;
                O_WGT:  st_d.wgt  = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (off_i)
            O_CTRL:  rdata_o = st_q.ctrl;
            O_HWM:   rdata_o = st_q.hwm;
            O_LWM:   rdata_o = st_q.lwm;
            O_AHWM:  rdata_o = st_q.ahwm;
            O_ALWM:  rdata_o = st_q.alwm;
            O_WGT:   rdata_o = st_q.wgt;
            O_AVG:   rdata_o = st_q.avg;
            O_STAT:  rdata_o = st_q.stat;
            default: rdata_o = '0;
        endcase
    end

    assign pend_o = st_q.ctrl[C_EN] &&
                    ((st_q.stat[S_RHI]  && st_q.ctrl[C_RHI_EN])  ||
                     (st_q.stat[S_RLO]  && st_q.ctrl[C_RLO_EN])  ||
                     (st_q.stat[S_AVHI] && st_q.ctrl[C_AVHI_EN]) ||
                     (st_q.stat[S_AVLO] && st_q.ctrl[C_AVLO_EN]));

    // R10
    idle_avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(wr_i && off_i == O_SEED)) |=> $stable(st_q.avg));

    // R7
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && off_i == O_STAT && (&wdata_i) && !take) |=> st_q.stat == '0);
endmodule

// File: rtl/am_monitor.sv
module am_monitor
    import am_pkg::*;
#(
    parameter int NCH = 2,
    parameter int PW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [NCH-1:0] evt_i,
    input  logic           reg_wr_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    output logic           irq_o
);
    logic [PW-1:0]  period;
    logic           pend;
    logic [DW-1:0]  ch_rd [NCH];
    logic [NCH-1:0] ch_pend;
    logic [NCH-1:0] ch_sel;
    logic [DW-1:0]  glb;

    am_tick_timer #(.PW(PW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i && reg_addr_i == G_PER),
        .wdata_i  (reg_wdata_i[PW-1:0]),
        .tick_i   (tick_i),
        .period_o (period),
        .pend_o   (pend)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [AW-1:0] BASE = CH_BASE0 + AW'(i) * CH_STRIDE;
        assign ch_sel[i] = reg_addr_i[AW-1:6] == BASE[AW-1:6];
        am_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (reg_wr_i && ch_sel[i]),
            .off_i   (reg_addr_i[5:0]),
            .wdata_i (reg_wdata_i),
            .samp_i  (pend),
            .evt_i   (evt_i[i]),
            .rdata_o (ch_rd[i]),
            .pend_o  (ch_pend[i])
        );
    end

    always_comb begin
        glb = '0;
        for (int i = 0; i < NCH; i++) glb[GSTAT_TOP-i] = ch_pend[i];
    end

    assign irq_o = |ch_pend;

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == G_STAT)     reg_rdata_o = glb;
        else if (reg_addr_i == G_PER) reg_rdata_o = {{(DW-PW){1'b0}}, period};
        for (int i = 0; i < NCH; i++)
            if (ch_sel[i]) reg_rdata_o = ch_rd[i];
    end

    // R9
    glb_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> glb != '0);
endmodule

// File: tb/am_monitor_tb.sv
`timescale 1ns/1ps
module am_monitor_tb;
    localparam int NCH = 2;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
    logic [NCH-1:0] evt = '0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic irq;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    am_monitor #(.NCH(NCH), .PW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .evt_i(evt),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    // reference model state
    logic [31:0] m_ctrl[NCH], m_hwm[NCH], m_lwm[NCH], m_ahwm[NCH], m_alwm[NCH];
    logic [31:0] m_wgt[NCH], m_acc[NCH], m_avg[NCH], m_stat[NCH];
    int m_rup[NCH], m_rdn[NCH];
    logic [7:0] m_per, m_tcnt;
    logic mp;

    function automatic logic [11:0] base(int c);
        return 12'h1C0 + 12'(c * 64);
    endfunction

    function automatic logic m_pend(int c);
        return m_ctrl[c][31] && ((m_stat[c][31] && m_ctrl[c][30]) || (m_stat[c][30] && m_ctrl[c][29]) ||
                                 (m_stat[c][29] && m_ctrl[c][21]) || (m_stat[c][28] && m_ctrl[c][20]));
    endfunction

    function automatic logic [31:0] m_glb();
        logic [31:0] g = '0;
        for (int c = 0; c < NCH; c++) g[26-c] = m_pend(c);
        return g;
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        logic [11:0] b;
        if (a == 12'h000) return m_glb();
        if (a == 12'h004) return {24'd0, m_per};
        for (int c = 0; c < NCH; c++) begin
            b = base(c);
            if (a[11:6] == b[11:6]) begin
                case (a[5:0])
                    6'h00: return m_ctrl[c];
                    6'h04: return m_hwm[c];
                    6'h08: return m_lwm[c];
                    6'h10: return m_ahwm[c];
                    6'h14: return m_alwm[c];
                    6'h18: return m_wgt[c];
                    6'h20: return m_avg[c];
                    6'h24: return m_stat[c];
                    default: return 32'd0;
                endcase
            end
        end
        return 32'd0;
    endfunction

    task automatic model_chan(int c, logic pe);
        logic act, take, wsel;
        logic [31:0] st, navg, nacc;
        logic [11:0] b;
        longint dlt;
        int sh;
        b    = base(c);
        act  = m_ctrl[c][31] && m_ctrl[c][18];
        take = act && pe;
        wsel = wr && (addr[11:6] == b[11:6]);
        st   = m_stat[c];
        if (wsel && addr[5:0] == 6'h24) st = st & ~wdata;
        navg = m_avg[c];
        nacc = act ? ((pe ? 32'd0 : m_acc[c]) + (evt[c] ? m_wgt[c] : 32'd0)) : 32'd0;
        if (take) begin
            sh   = int'(m_ctrl[c][12:10]) + 1;
            dlt  = (longint'(m_acc[c]) - longint'(m_avg[c])) >>> sh;
            navg = m_avg[c] + dlt[31:0];
            if (m_acc[c] > m_hwm[c]) begin
                if (m_rup[c] == int'(m_ctrl[c][28:26])) begin st[31] = 1'b1; m_rup[c] = 0; end
                else m_rup[c] = (m_rup[c] + 1) & 7;
            end else m_rup[c] = 0;
            if (m_acc[c] < m_lwm[c]) begin
                if (m_rdn[c] == int'(m_ctrl[c][25:23])) begin st[30] = 1'b1; m_rdn[c] = 0; end
                else m_rdn[c] = (m_rdn[c] + 1) & 7;
            end else m_rdn[c] = 0;
            if (navg > m_ahwm[c]) st[29] = 1'b1;
            if (navg < m_alwm[c]) st[28] = 1'b1;
        end else if (!act) begin
            m_rup[c] = 0;
            m_rdn[c] = 0;
        end
        if (wsel) begin
            case (addr[5:0])
                6'h00: m_ctrl[c] = wdata;
                6'h04: m_hwm[c]  = wdata;
                6'h08: m_lwm[c]  = wdata;
                6'h0C: navg      = wdata;
                6'h10: m_ahwm[c] = wdata;
                6'h14: m_alwm[c] = wdata;
                6'h18: m_wgt[c]  = wdata;
                default: ;
            endcase
        end
        m_acc[c]  = nacc;
        m_avg[c]  = navg;
        m_stat[c] = st;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_per = '0; m_tcnt = '0;
            for (int c = 0; c < NCH; c++) begin
                m_ctrl[c] = '0; m_hwm[c] = '0; m_lwm[c] = '0; m_ahwm[c] = '0; m_alwm[c] = '0;
                m_wgt[c] = '0; m_acc[c] = '0; m_avg[c] = '0; m_stat[c] = '0;
                m_rup[c] = 0; m_rdn[c] = 0;
            end
        end else begin
            mp = tick && (m_tcnt == m_per);
            for (int c = 0; c < NCH; c++) model_chan(c, mp);
            if (tick) m_tcnt = mp ? 8'd0 : m_tcnt + 8'd1;
            if (wr && addr == 12'h004) m_per = wdata[7:0];
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic rd_chk(string tag, logic [11:0] a);
        addr = a;
        #1;
        chk(tag, rdata, m_read(a));
    endtask

    task automatic wr_reg(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        evt = '0; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    int rr = 0;
    task automatic cyc(int d0, int d1, int td);
        logic [11:0] a;
        @(negedge clk);
        wr     = 1'b0;
        evt[0] = ($urandom % 100) < d0;
        evt[1] = ($urandom % 100) < d1;
        tick   = ($urandom % 100) < td;
        case (rr % 6)
            0: rd_chk("R9 global status", 12'h000);
            1: rd_chk("R1 R2 ch0 average", base(0) + 12'h20);
            2: rd_chk("R1 R2 ch1 average", base(1) + 12'h20);
            3, 4: begin
                a = base(rr % 6 - 3) + 12'h24;
                addr = a; #1;
                chk("R4 consecutive-above bit", {31'd0, rdata[31]}, {31'd0, m_read(a) >> 31});
                chk("R5 consecutive-below bit", {31'd0, rdata[30]}, {31'd0, m_read(a) >> 30 & 32'd1});
                chk("R6 average bits", {30'd0, rdata[29:28]}, (m_read(a) >> 28) & 32'd3);
            end
            default: rd_chk("R1 period register", 12'h004);
        endcase
        chk("R8 irq", {31'd0, irq}, {31'd0, m_glb() != 0});
        rr++;
    endtask

    // enable, periodic, all interrupt enables
    localparam logic [31:0] CTRL_ON = (32'd1 << 31) | (32'd1 << 30) | (32'd1 << 29) |
                                      (32'd1 << 21) | (32'd1 << 20) | (32'd1 << 18);

    initial begin
        logic [31:0] saved;
        int d0, d1, td;
        void'($urandom(32'd24681357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 irq after reset", {31'd0, irq}, 32'd0);
        addr = 12'h000; #1; chk("R11 global status", rdata, 32'd0);
        @(negedge clk);
        addr = base(0); #1; chk("R11 ch0 control", rdata, 32'd0);
        @(negedge clk);
        addr = base(1) + 12'h20; #1; chk("R11 ch1 average", rdata, 32'd0);

        wr_reg(12'h004, 32'd3);
        // R3 seed
        wr_reg(base(0) + 12'h0C, 32'd1000);
        addr = base(0) + 12'h20; #1; chk("R3 seeded average", rdata, 32'd1000);

        // R10 disabled channel ignores events
        wr_reg(base(0) + 12'h18, 32'd1024);
        wr_reg(base(0), 32'd1 << 31);
        repeat (30) cyc(100, 0, 100);
        @(negedge clk);
        addr = base(0) + 12'h20; #1; chk("R10 avg held while idle", rdata, 32'd1000);
        @(negedge clk);
        addr = base(0) + 12'h24; #1; chk("R10 status held while idle", rdata, 32'd0);

        // channel configuration
        wr_reg(base(0) + 12'h04, 32'd2500);
        wr_reg(base(0) + 12'h08, 32'd1000);
        wr_reg(base(0) + 12'h10, 32'd2800);
        wr_reg(base(0) + 12'h14, 32'd800);
        wr_reg(base(0), CTRL_ON | (32'd1 << 10) | (32'd2 << 23));
        wr_reg(base(1) + 12'h18, 32'd7);
        wr_reg(base(1) + 12'h04, 32'd20);
        wr_reg(base(1) + 12'h08, 32'd8);
        wr_reg(base(1) + 12'h10, 32'd22);
        wr_reg(base(1) + 12'h14, 32'd6);
        wr_reg(base(1), CTRL_ON | (32'd2 << 10) | (32'd1 << 26) | (32'd1 << 23));

        for (int ph = 0; ph < 8; ph++) begin
            wr_reg(12'h004, 32'($urandom_range(1, 5)));
            case (ph % 4)
                0: begin d0 = 90; d1 = 90; end
                1: begin d0 = 10; d1 = 10; end
                2: begin d0 = 95; d1 = 5;  end
                default: begin d0 = 50; d1 = 50; end
            endcase
            td = (ph < 4) ? 100 : 70;
            if (ph == 5) begin
                wr_reg(base(1), 32'd0);
                @(negedge clk);
                addr = base(1) + 12'h20; #1; saved = rdata;
            end
            for (int n = 0; n < 300; n++) begin
                cyc(d0, d1, td);
                if (n % 40 == 39) begin
                    wr_reg(base(ph % 2) + 12'h24, 32'hFFFF_FFFF);
                    addr = base(ph % 2) + 12'h24; #1;
                    chk("R7 status after clear", rdata, m_read(base(ph % 2) + 12'h24));
                end
            end
            if (ph == 5) begin
                @(negedge clk);
                addr = base(1) + 12'h20; #1; chk("R10 ch1 avg held while off", rdata, saved);
                wr_reg(base(1), CTRL_ON | (32'd2 << 10) | (32'd1 << 26) | (32'd1 << 23));
            end
        end
        // R7 full clear with sampling stopped
        wr_reg(12'h004, 32'd200);
        wr_reg(base(0) + 12'h24, 32'hFFFF_FFFF);
        addr = base(0) + 12'h24; #1; chk("R7 cleared", rdata, 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R11: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule